// File: doc/BRIEF.md
# Charge-Unit Interrupt Servicer

This block is the host-side logic that sits next to a coulomb-counting chip. The chip pulls an active-low interrupt line each time a fixed unit of charge passes through the battery. It also latches a polarity line showing the direction of that unit. The servicer synchronizes both lines and spots the falling edge of the interrupt. It reads the polarity while the interrupt is still held, then adds or subtracts one unit from a signed running total. It then drives the chip's active-low clear input for a programmable minimum number of cycles.

Separate unsigned counters record how many units went into the battery and how many came out. The signed total saturates instead of wrapping, and a sticky flag reports that it did. A watchdog timer starts at detection. If the block has not re-armed within a programmable number of cycles, it raises a sticky overrun flag, because a late service means the chip may have dropped a unit. A shutdown request keeps the block from accepting new interrupts. Scaling counts to ampere-hours is left to software, since one unit corresponds to a fixed charge set by the sense resistor and the chip's gain.

Top module: `charge_unit_servicer`

## Requirements
- R1: With the block armed and `shutdown` low, a high-to-low change on `irq_n_in` drives `clr_n` low after the third rising clock edge that follows the change. The totals update on that same edge.
- R2: If `pol_in` (high = charge into the battery) is high at the sampled interrupt, `acc` increases by one and `chg_count` increases by one. If it is low, `acc` decreases by one and `dis_count` increases by one.
- R3: `clr_n` stays low for exactly `clr_width` clock cycles. A `clr_width` of 0 is treated as 1.
- R4: After `clr_n` is released, the block re-arms only once it sees `irq_n_in` high. An interrupt line that stays low past the clear is therefore counted once.
- R5: `overrun` is set if the block has not re-armed within `svc_timeout` cycles of detection, and it stays set until reset. Services that finish well inside the limit leave it at 0.
- R6: `acc` saturates at its largest positive and most negative values and never wraps. The first step that would pass a limit sets `saturated`, which then stays set. `chg_count` and `dis_count` keep counting regardless.
- R7: While `shutdown` is high and the block is armed, no interrupt is accepted, `clr_n` stays high and the totals do not change. An interrupt still pending when `shutdown` falls is serviced, with `clr_n` low after the next rising edge.
- R8: After reset, `clr_n` is 1, `acc`, `chg_count` and `dis_count` are 0, and `overrun` and `saturated` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all totals and flags |
| shutdown | input | 1 | Stops new interrupts from being accepted and freezes the totals |
| irq_n_in | input | 1 | Active-low charge-unit interrupt from the counter chip (asynchronous) |
| pol_in | input | 1 | Polarity from the chip; 1 = charge in, 0 = charge out (asynchronous) |
| clr_width | input | CLRW_W | Clear pulse low time in cycles (0 acts as 1) |
| svc_timeout | input | TMO_W | Cycles allowed from detection to re-arm |
| clr_n | output | 1 | Active-low clear to the chip |
| acc | output | ACC_W | Signed saturating net charge in units |
| chg_count | output | CNT_W | Units that went into the battery |
| dis_count | output | CNT_W | Units that came out of the battery |
| overrun | output | 1 | Sticky: a service exceeded its deadline |
| saturated | output | 1 | Sticky: `acc` reached a limit and held there |

## Verification
The accumulator is exercised with alternating polarities, which separates the up path from the down path. Long runs of a single polarity drive the total into both of its limits, which shows saturation apart from wrap-around. A chip model that holds the interrupt low long after the clear shows whether the block re-arms on level or on edge. A clear width of zero and other widths check the pulse counter. An interrupt raised during shutdown shows whether the request is blocked and then serviced late rather than lost. A deliberately short timeout next to a generous one shows that the overrun flag responds to service length and nothing else.

// File: rtl/charge_unit_servicer.sv
module charge_unit_servicer #(
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 32,
  parameter int CLRW_W = 16,
  parameter int TMO_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shutdown,
  input  logic                    irq_n_in,
  input  logic                    pol_in,
  input  logic [CLRW_W-1:0]       clr_width,
  input  logic [TMO_W-1:0]        svc_timeout,
  output logic                    clr_n,
  output logic signed [ACC_W-1:0] acc,
  output logic [CNT_W-1:0]        chg_count,
  output logic [CNT_W-1:0]        dis_count,
  output logic                    overrun,
  output logic                    saturated
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_ARMED, S_CLEAR, S_REARM} state_t;

  state_t            st;
  logic [1:0]        irq_sync, pol_sync;
  logic              irq_prev;
  logic [CLRW_W-1:0] clr_cnt;
  logic [TMO_W-1:0]  timer;

  wire irq_s = irq_sync[1];
  wire pol_s = pol_sync[1];
  wire take  = (st == S_ARMED) && !shutdown && irq_prev && !irq_s;
  wire [CLRW_W-1:0] eff_w = (clr_width == '0) ? CLRW_W'(1) : clr_width;
  wire rearm_now = (st == S_REARM) && irq_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sync <= 2'b11;
      pol_sync <= 2'b00;
      irq_prev <= 1'b1;
    end else begin
      irq_sync <= {irq_sync[0], irq_n_in};
      pol_sync <= {pol_sync[0], pol_in};
      irq_prev <= shutdown ? 1'b1 : irq_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_ARMED;
      clr_n     <= 1'b1;
      clr_cnt   <= '0;
      timer     <= '0;
      acc       <= '0;
      chg_count <= '0;
      dis_count <= '0;
      overrun   <= 1'b0;
      saturated <= 1'b0;
    end else begin
      case (st)
        S_ARMED: if (take) begin
          st      <= S_CLEAR;
          clr_n   <= 1'b0;
          clr_cnt <= CLRW_W'(1);
          timer   <= TMO_W'(1);
          if (pol_s) begin
            chg_count <= chg_count + CNT_W'(1);
            if (acc == ACC_MAX) saturated <= 1'b1;
            else                acc       <= acc + ONE;
          end else begin
            dis_count <= dis_count + CNT_W'(1);
            if (acc == ACC_MIN) saturated <= 1'b1;
            else                acc       <= acc - ONE;
          end
        end
        S_CLEAR: begin
          if (clr_cnt >= eff_w) begin
            clr_n <= 1'b1;
            st    <= S_REARM;
          end else begin
            clr_cnt <= clr_cnt + CLRW_W'(1);
          end
        end
        S_REARM: if (irq_s) st <= S_ARMED;
        default: st <= S_ARMED;
      endcase

      if (st != S_ARMED && !rearm_now) begin
        if (timer != '1) timer <= timer + TMO_W'(1);
        if (timer >= svc_timeout) overrun <= 1'b1;
      end
    end
  end

  logic [CLRW_W:0] a_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          a_low_run <= '0;
    else if (clr_n)                      a_low_run <= '0;
    else if (a_low_run != '1)            a_low_run <= a_low_run + (CLRW_W+1)'(1);
  end

  assert_clear_follows_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !clr_n);

  assert_clear_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> (a_low_run >= {1'b0, eff_w}));

  assert_no_recount_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REARM && !irq_s) |=> ($stable(chg_count) && $stable(dis_count)));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_no_wrap_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_MAX) |=> (acc == ACC_MAX || acc == ACC_MAX - ONE));

  assert_no_wrap_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_MIN) |=> (acc == ACC_MIN || acc == ACC_MIN + ONE));

  assert_saturated_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    saturated |=> saturated);

  assert_shutdown_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && st == S_ARMED) |=> ($stable(acc) && clr_n));

endmodule

// File: tb/test_charge_unit_servicer.sv
module test_charge_unit_servicer;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 4, CNT_W = 8, CLRW_W = 8, TMO_W = 16;
  localparam int AMAX = (1 << (ACC_W-1)) - 1;
  localparam int AMIN = -(1 << (ACC_W-1));

  logic clk = 0, rst_n = 0, shutdown = 0, irq_n_in = 1, pol_in = 0;
  logic [CLRW_W-1:0] clr_width = 4;
  logic [TMO_W-1:0]  svc_timeout = 1000;
  logic clr_n, overrun, saturated;
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0] chg_count, dis_count;

  charge_unit_servicer #(.ACC_W(ACC_W), .CNT_W(CNT_W), .CLRW_W(CLRW_W), .TMO_W(TMO_W)) i_charge_unit_servicer (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .irq_n_in(irq_n_in), .pol_in(pol_in),
    .clr_width(clr_width), .svc_timeout(svc_timeout), .clr_n(clr_n), .acc(acc),
    .chg_count(chg_count), .dis_count(dis_count), .overrun(overrun), .saturated(saturated));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_err = 0, cyc = 0;
  int m_acc = 0, m_chg = 0, m_dis = 0, m_sat = 0;
  int qa[$], qc[$], qd[$];
  int drop_cyc = 0, exp_lat = 3, exp_w = 4;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic pol);
    if (pol) begin
      m_chg = (m_chg + 1) % (1 << CNT_W);
      if (m_acc == AMAX) m_sat = 1; else m_acc++;
    end else begin
      m_dis = (m_dis + 1) % (1 << CNT_W);
      if (m_acc == AMIN) m_sat = 1; else m_acc--;
    end
    qa.push_back(m_acc); qc.push_back(m_chg); qd.push_back(m_dis);
  endtask

  task automatic finish_service(input int extra_low);
    while (clr_n) @(negedge clk);
    repeat (2) @(negedge clk);
    if (extra_low > 0) begin
      while (!clr_n) @(negedge clk);
      repeat (extra_low) @(negedge clk);
    end
    irq_n_in = 1;
    while (!clr_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic fire(input logic pol, input int extra_low);
    @(negedge clk);
    model_step(pol);
    pol_in = pol; irq_n_in = 0; drop_cyc = cyc; exp_lat = 3;
    finish_service(extra_low);
  endtask

  // monitor: pops expected totals at each start of clear, measures clear width
  logic prev_clr = 1;
  int low_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_clr && !clr_n) begin
        if (qa.size() == 0) begin
          chk("R4 unexpected service", 1, 0);
        end else begin
          chk("R1 clear latency", cyc - drop_cyc, exp_lat);
          chk("R2 acc", int'(acc), qa.pop_front());
          chk("R2 chg_count", int'(chg_count), qc.pop_front());
          chk("R2 dis_count", int'(dis_count), qd.pop_front());
        end
      end
      if (!clr_n) low_cnt++;
      if (!prev_clr && clr_n) begin
        chk("R3 clear width", low_cnt, exp_w);
        low_cnt = 0;
      end
    end
    prev_clr = clr_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 clr_n", int'(clr_n), 1);
    chk("R8 acc", int'(acc), 0);
    chk("R8 chg_count", int'(chg_count), 0);
    chk("R8 dis_count", int'(dis_count), 0);
    chk("R8 overrun", int'(overrun), 0);
    chk("R8 saturated", int'(saturated), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R2: mixed polarities
    fire(1, 0); fire(0, 0); fire(1, 0); fire(1, 0); fire(0, 0);

    // R4: interrupt held low long after clear is released
    fire(0, 10);
    repeat (10) @(negedge clk);
    chk("R4 dis_count single count", int'(dis_count), m_dis);
    chk("R4 acc single count", int'(acc), m_acc);
    fire(1, 0);

    // R3: widths 1, 0 (acts as 1), 9
    clr_width = 1; exp_w = 1; fire(0, 0);
    clr_width = 0; exp_w = 1; fire(1, 0);
    clr_width = 9; exp_w = 9; fire(0, 0);
    clr_width = 4; exp_w = 4;

    // R7: interrupt arriving during shutdown
    @(negedge clk);
    shutdown = 1;
    @(negedge clk);
    pol_in = 0; irq_n_in = 0;
    repeat (12) @(negedge clk);
    chk("R7 clr_n held high", int'(clr_n), 1);
    chk("R7 acc frozen", int'(acc), m_acc);
    chk("R7 dis_count frozen", int'(dis_count), m_dis);
    model_step(0);
    drop_cyc = cyc; exp_lat = 1;
    shutdown = 0;
    finish_service(0);
    chk("R7 pending serviced", int'(dis_count), m_dis);

    // R5: generous timeout leaves overrun clear
    chk("R5 overrun after normal services", int'(overrun), 0);

    // R6: run up into positive limit, then down into negative limit
    chk("R6 saturated before limit", int'(saturated), 0);
    while (m_acc < AMAX) fire(1, 0);
    chk("R6 acc at max", int'(acc), AMAX);
    chk("R6 saturated not yet", int'(saturated), 0);
    fire(1, 0);
    chk("R6 acc held at max", int'(acc), AMAX);
    chk("R6 saturated set", int'(saturated), 1);
    chk("R6 chg_count still counts", int'(chg_count), m_chg);
    while (m_acc > AMIN) fire(0, 0);
    fire(0, 0);
    chk("R6 acc held at min", int'(acc), AMIN);
    chk("R6 saturated sticky", int'(saturated), 1);
    fire(1, 0);
    chk("R6 acc leaves min", int'(acc), AMIN + 1);

    // R5: tight timeout against long clear
    svc_timeout = 5; clr_width = 12; exp_w = 12;
    fire(1, 0);
    chk("R5 overrun set", int'(overrun), 1);
    svc_timeout = 1000; clr_width = 4; exp_w = 4;
    fire(0, 0);
    chk("R5 overrun sticky", int'(overrun), 1);

    chk("R4 no leftover expected services", qa.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule